// File: doc/BRIEF.md
# Fuse Range CRC32 Checker

This block verifies the integrity of a stretch of one-time-programmable fuse words. Software writes a start word address, an end word address and a 2-bit reference selector into a range register, then sets a trigger bit in the control register. The block then fetches each 32-bit fuse word of the inclusive range through a single-word read port and folds it into a reflected CRC32, one byte per clock. When the walk is done it reads one of four reference words from a reserved fuse row and compares the two values.

The finished CRC is kept in a read-only result register. A mismatch sets a sticky fail flag, which software clears by writing a one to it. The trigger bit reads back as one for the whole calculation and clears itself at the completion edge. A `busy` output marks the same interval. The fuse array, its programming and the system bus are outside the block. The fuse read port expects data one cycle after the request.

Top module: `fuse_crc_checker`

## Requirements
- R1: After reset the control, range and result registers read 0x00000000, and `busy` and `fuse_rd` are low.
- R2: Register addresses are 0 for control, 1 for range and 2 for result. A write to control with bit 0 set, made while idle, starts a calculation. From the next cycle control bit 0 (trigger) reads 1 and `busy` is high.
- R3: The range register holds the start address in bits 7:0, the end address in bits 15:8 and the reference selector in bits 17:16. All other bits read as zero.
- R4: Each word from start to end inclusive is requested exactly once, in ascending order, with a one-cycle `fuse_rd` pulse. Each word takes six cycles: the request, a data-capture cycle, and four byte cycles.
- R5: The result is the reflected CRC32: polynomial 0x04C11DB7 (0xEDB88320 reflected), initial value 0xFFFFFFFF and final XOR 0xFFFFFFFF. Each word is fed least significant byte first.
- R6: When start is greater than end, no data word is read and the result is 0x00000000.
- R7: After the walk, the reference word at address 252 + selector is read (two cycles). A difference from the result sets control bit 1 (fail). The fail bit is sticky and is not cleared by a later matching run.
- R8: Writing control with bit 1 set clears fail. If a mismatch completes in the same cycle, fail stays set.
- R9: `busy` and trigger stay high for exactly 6·N+2 cycles for N words. Both fall at the edge on which the result register is updated.
- R10: While busy, writes to the range register and start requests are ignored.
- R11: The result register holds the last completed CRC, and bus writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 control, 1 range, 2 result) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| busy | output | 1 | High while a calculation runs |
| fuse_rd | output | 1 | Fuse word read request |
| fuse_addr | output | 8 | Fuse word address |
| fuse_rdata | input | 32 | Fuse word data, valid the cycle after `fuse_rd` |

## Verification
The fail flag has two writers: the comparison that ends a walk sets it, and a software write clears it. Both can land on the same clock edge. The bench provokes this by issuing the clearing write on exactly the cycle the comparison completes, once with a mismatching reference and once with a matching one. It judges the outcome by reading the flag back: a mismatch must leave it set, and a match must let the clear take effect. The same cycle-level model also checks that a start request and a range write arriving mid-walk change neither the address sequence nor the result.

// File: rtl/fcrc_pkg.sv
package fcrc_pkg;

  typedef enum logic [1:0] {
    RA_CTRL   = 2'd0,
    RA_RANGE  = 2'd1,
    RA_RESULT = 2'd2
  } reg_sel_e;

  typedef enum logic [2:0] {
    W_IDLE,
    W_FETCH,
    W_LATCH,
    W_SHIFT,
    W_REF_FETCH,
    W_REF_CMP
  } walk_st_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
  localparam int          END_LSB       = 8;
  localparam int          SEL_LSB       = 16;

  // One byte through the reflected CRC32 register, bit 0 first.
  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/fcrc_engine.sv
module fcrc_engine
  import fcrc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        step,
  input  logic [7:0]  byte_in,
  output logic [31:0] crc_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= '1;
    else if (init) crc_q <= '1;
    else if (step) crc_q <= crc32_byte(crc_q, byte_in);
  end

endmodule

// File: rtl/fcrc_walker.sv
module fcrc_walker
  import fcrc_pkg::*;
#(
  parameter int          AW       = 8,
  parameter int          DW       = 32,
  parameter int unsigned REF_BASE = 252
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] rng_start,
  input  logic [AW-1:0] rng_end,
  input  logic [1:0]    ref_sel,
  output logic          fuse_rd,
  output logic [AW-1:0] fuse_addr,
  input  logic [DW-1:0] fuse_rdata,
  input  logic [31:0]   crc_q,
  output logic          eng_init,
  output logic          eng_step,
  output logic [7:0]    eng_byte,
  output logic          busy,
  output logic          done,
  output logic          mismatch,
  output logic [31:0]   final_crc
);

  localparam int            NB      = DW / 8;
  localparam int            BW      = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [AW-1:0] REF_ROW = AW'(REF_BASE);

  walk_st_e      st;
  logic [AW-1:0] cur;
  logic [DW-1:0] sh;
  logic [BW-1:0] bcnt;

  // named internal events
  logic last_byte, last_word, word_done, empty_start;
  logic [AW-1:0] ref_addr;

  assign last_byte   = (bcnt == BW'(NB - 1));
  assign last_word   = (cur == rng_end);
  assign word_done   = (st == W_SHIFT) && last_byte;
  assign empty_start = start && (rng_start > rng_end);
  assign ref_addr    = REF_ROW + AW'(ref_sel);

  assign fuse_rd   = (st == W_FETCH) || (st == W_REF_FETCH);
  assign fuse_addr = (st == W_REF_FETCH) ? ref_addr : cur;
  assign eng_init  = start;
  assign eng_step  = (st == W_SHIFT);
  assign eng_byte  = sh[7:0];
  assign busy      = (st != W_IDLE);
  assign done      = (st == W_REF_CMP);
  assign final_crc = ~crc_q;
  assign mismatch  = (final_crc != fuse_rdata[31:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= W_IDLE;
      cur  <= '0;
      sh   <= '0;
      bcnt <= '0;
    end else begin
      unique case (st)
        W_IDLE: if (start) begin
          cur <= rng_start;
          st  <= empty_start ? W_REF_FETCH : W_FETCH;
        end
        W_FETCH: st <= W_LATCH;
        W_LATCH: begin
          sh   <= fuse_rdata;
          bcnt <= '0;
          st   <= W_SHIFT;
        end
        W_SHIFT: begin
          sh   <= sh >> 8;
          bcnt <= bcnt + 1'b1;
          if (last_byte) begin
            if (last_word) st <= W_REF_FETCH;
            else begin
              cur <= cur + 1'b1;
              st  <= W_FETCH;
            end
          end
        end
        W_REF_FETCH: st <= W_REF_CMP;
        W_REF_CMP:   st <= W_IDLE;
        default:     st <= W_IDLE;
      endcase
    end
  end

  assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_rd |=> !fuse_rd);
  assert_fetch_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == W_FETCH) |-> (cur >= rng_start && cur <= rng_end));
  assert_walk_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !last_word) |=> (fuse_rd && fuse_addr == $past(cur) + 1'b1));
  assert_empty_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    empty_start |=> (fuse_rd && fuse_addr == ref_addr));
  assert_done_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/fcrc_regs.sv
module fcrc_regs
  import fcrc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          busy,
  input  logic          done,
  input  logic          mismatch,
  input  logic [31:0]   final_crc,
  output logic          start,
  output logic          trig,
  output logic [AW-1:0] rng_start,
  output logic [AW-1:0] rng_end,
  output logic [1:0]    ref_sel
);

  logic        fail_q;
  logic [31:0] result_q;
  logic        wr_ctrl, wr_range, clr_fail, fail_set, unused_wdata;

  assign wr_ctrl      = reg_we && (reg_addr == RA_CTRL);
  assign wr_range     = reg_we && (reg_addr == RA_RANGE) && !busy && !trig;
  assign start        = wr_ctrl && reg_wdata[0] && !busy && !trig;
  assign clr_fail     = wr_ctrl && reg_wdata[1];
  assign fail_set     = done && mismatch;
  assign unused_wdata = ^reg_wdata[31:SEL_LSB+2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig      <= 1'b0;
      fail_q    <= 1'b0;
      result_q  <= '0;
      rng_start <= '0;
      rng_end   <= '0;
      ref_sel   <= '0;
    end else begin
      if (start)     trig <= 1'b1;
      else if (done) trig <= 1'b0;
      // hardware set has priority over software clear
      if (fail_set)      fail_q <= 1'b1;
      else if (clr_fail) fail_q <= 1'b0;
      if (done) result_q <= final_crc;
      if (wr_range) begin
        rng_start <= reg_wdata[AW-1:0];
        rng_end   <= reg_wdata[END_LSB +: AW];
        ref_sel   <= reg_wdata[SEL_LSB +: 2];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_CTRL:   reg_rdata[1:0] = {fail_q, trig};
      RA_RANGE: begin
        reg_rdata[AW-1:0]         = rng_start;
        reg_rdata[END_LSB +: AW]  = rng_end;
        reg_rdata[SEL_LSB +: 2]   = ref_sel;
      end
      RA_RESULT: reg_rdata = result_q;
      default:   reg_rdata = '0;
    endcase
  end

  assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !clr_fail) |=> fail_q);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mismatch) |=> fail_q);
  assert_range_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({rng_start, rng_end, ref_sel}));
  assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(result_q));

endmodule

// File: rtl/fuse_crc_checker.sv
module fuse_crc_checker
  import fcrc_pkg::*;
#(
  parameter int          AW       = 8,
  parameter int          DW       = 32,
  parameter int unsigned REF_BASE = 252
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          busy,
  output logic          fuse_rd,
  output logic [AW-1:0] fuse_addr,
  input  logic [DW-1:0] fuse_rdata
);

  logic          start, trig, done, mismatch;
  logic          eng_init, eng_step;
  logic [7:0]    eng_byte;
  logic [31:0]   crc_q, final_crc;
  logic [AW-1:0] rng_start, rng_end;
  logic [1:0]    ref_sel;

  fcrc_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done(done),
    .mismatch(mismatch), .final_crc(final_crc), .start(start), .trig(trig),
    .rng_start(rng_start), .rng_end(rng_end), .ref_sel(ref_sel)
  );

  fcrc_walker #(.AW(AW), .DW(DW), .REF_BASE(REF_BASE)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .rng_start(rng_start),
    .rng_end(rng_end), .ref_sel(ref_sel), .fuse_rd(fuse_rd),
    .fuse_addr(fuse_addr), .fuse_rdata(fuse_rdata), .crc_q(crc_q),
    .eng_init(eng_init), .eng_step(eng_step), .eng_byte(eng_byte),
    .busy(busy), .done(done), .mismatch(mismatch), .final_crc(final_crc)
  );

  fcrc_engine u_eng (
    .clk(clk), .rst_n(rst_n), .init(eng_init), .step(eng_step),
    .byte_in(eng_byte), .crc_q(crc_q)
  );

  assert_trig_tracks_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trig == busy);
  assert_rd_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_rd |-> busy);
  assert_start_raises_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && trig));

endmodule

// File: tb/fuse_crc_checker_tb.sv
`timescale 1ns/1ps
module fuse_crc_checker_tb;

  localparam int REF_BASE = 252;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        busy, fuse_rd;
  logic [7:0]  fuse_addr;
  logic [31:0] fuse_rdata = '0;
  logic [31:0] mem [256];

  int  checks = 0;
  int  errors = 0;
  bit  model_fail = 1'b0;

  always #2 clk = ~clk;

  fuse_crc_checker u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .fuse_rd(fuse_rd), .fuse_addr(fuse_addr), .fuse_rdata(fuse_rdata)
  );

  // fuse array model: registered read, one cycle latency
  always @(posedge clk) if (fuse_rd) fuse_rdata <= mem[fuse_addr];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bitwise, whole word at once, bit 0 first (equals byte-wise LSB first)
  function automatic logic [31:0] model_crc(input int s, input int e);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int a = s; a <= e; a++) begin
      for (int b = 0; b < 32; b++) begin
        if ((c[0] ^ mem[a][b]) == 1'b1) c = (c >> 1) ^ 32'hEDB8_8320;
        else c = c >> 1;
      end
    end
    return ~c;
  endfunction

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_we = 1'b0; reg_addr = a; #1; v = reg_rdata;
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic run(input int s, input int e, input int sel, input bit inj, input bit clr_end);
    int n, total;
    logic [31:0] exp_crc, v, rng_word;
    bit mm, exp_rd;
    n = (s > e) ? 0 : e - s + 1;
    exp_crc = model_crc(s, e);
    mm = (exp_crc != mem[REF_BASE + sel]);
    rng_word = {14'd0, sel[1:0], e[7:0], s[7:0]};
    wr(2'd1, rng_word);
    wr(2'd0, 32'h1);
    total = 6 * n + 2;
    for (int k = 0; k < total; k++) begin
      reg_we = 1'b0; reg_addr = 2'd0; #1;
      if (k == 0) chk("R2 trigger readback", {31'd0, reg_rdata[0]}, 32'd1);
      chk("R9 busy during walk", {31'd0, busy}, 32'd1);
      exp_rd = (k < 6 * n && k % 6 == 0) || k == 6 * n;
      chk("R4 fuse_rd timing", {31'd0, fuse_rd}, {31'd0, exp_rd});
      if (exp_rd && fuse_rd) begin
        if (k < 6 * n) chk("R4 word address", {24'd0, fuse_addr}, (s + k / 6) & 255);
        else chk("R7 reference address", {24'd0, fuse_addr}, REF_BASE + sel);
      end
      if (inj && k == 3) begin
        reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0002_3344;
      end
      if (inj && k == 4) begin
        reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h1;
      end
      if (clr_end && k == total - 1) begin
        reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h2;
      end
      @(negedge clk);
    end
    reg_we = 1'b0;
    model_fail = mm | (clr_end ? 1'b0 : model_fail);
    chk("R9 busy falls", {31'd0, busy}, 32'd0);
    rd(2'd2, v); chk("R5 crc result", v, exp_crc);
    rd(2'd0, v);
    chk("R9 trigger self-clears", {31'd0, v[0]}, 32'd0);
    chk(clr_end ? "R8 fail with same-cycle clear" : "R7 fail flag",
        {31'd0, v[1]}, {31'd0, model_fail});
    if (inj) begin
      rd(2'd1, v); chk("R10 range unchanged after busy write", v, rng_word);
      chk("R10 no restart", {31'd0, busy}, 32'd0);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, last;
    for (int i = 0; i < 256; i++) mem[i] = (i * 32'h9E37_79B9) ^ (i << 7) ^ 32'h5A5A_0F0F;
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk("R1 ctrl reset", v, 0);
    rd(2'd1, v); chk("R1 range reset", v, 0);
    rd(2'd2, v); chk("R1 result reset", v, 0);
    chk("R1 busy reset", {31'd0, busy}, 0);
    chk("R1 fuse_rd reset", {31'd0, fuse_rd}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R3 range field layout", v, 32'h0003_FFFF);

    mem[252] = model_crc(10, 13);
    run(10, 13, 0, 0, 0);                 // R5 multi-word match
    mem[253] = model_crc(5, 5) ^ 32'h1;
    run(5, 5, 1, 0, 0);                   // single word, mismatch
    run(10, 13, 0, 0, 0);                 // R7 sticky across match
    wr(2'd0, 32'h2); model_fail = 1'b0;
    rd(2'd0, v); chk("R8 software clear", {31'd0, v[1]}, 0);
    mem[254] = 32'h0;
    run(20, 10, 2, 0, 0);                 // R6 empty range
    mem[255] = model_crc(0, 7);
    run(0, 7, 3, 1, 0);                   // R10 busy writes
    run(30, 31, 0, 0, 1);                 // R8 mismatch + clear same cycle
    run(10, 13, 0, 0, 1);                 // R8 match + clear same cycle
    rd(2'd2, last);
    wr(2'd2, 32'hDEAD_BEEF);
    rd(2'd2, v); chk("R11 result write ignored", v, last);
    run(250, 255, 3, 0, 0);               // top-of-array range

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule